// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

One channel of a periodic interrupt timer. Software uses a small register port to write an interval value. A down counter loads that value minus one and counts toward zero, one step per clock. A running channel whose counter is zero is at terminal count. At terminal count the channel raises a sticky interrupt flag. It then either reloads the interval (repeat mode) or stops (one-shot mode).

A write to the interval register can do four things: start an idle channel, retarget a running one, restart it or stop it. Bit 31 of the written word, the force bit, picks when this happens. With the force bit set, the write acts on the counter at once. With it clear, the counter finishes the current interval first and the new value applies at the next reload. The force bit is not stored.

The port is a single-cycle write strobe with a combinational read. The address map is:

| Address | Register |
|---|---|
| 0 | interval |
| 1 | counter, read-only |
| 2 | status: bit 0 interrupt flag, clear by writing 1; bit 1 running, read-only |

Top module: `ivl_timer_chan`

## Requirements
- R1: After reset, the following all read zero: the interval (address 0), the counter (address 1) and the status (address 2). The `irq` output is low.
- R2: Writing a non-zero value V in bits 23:0 of address 0 while idle starts the channel at that edge. The counter then reads V-1, and it drops by one on every clock until it reaches zero.
- R3: At each edge where the channel is running with the counter at zero, the interrupt flag (status bit 0, `irq`) is set. The flag stays set until a write to address 2 with bit 0 high. A write with bit 0 low leaves it set. If a set and a clear fall on the same edge, the set wins.
- R4: In repeat mode (`repeat_mode`=1), terminal count reloads the counter with the interval value minus one. A write at that same edge counts as part of the interval value. The flag is therefore set every V cycles.
- R5: In one-shot mode (`repeat_mode`=0), terminal count stops the channel. Status bit 1 drops and the counter stays at zero.
- R6: A non-zero value V written with bit 31 set while running loads V-1 into the counter at that edge.
- R7: Zero written with bit 31 set while running stops the channel at that edge, with the counter cleared.
- R8: A non-zero value written with bit 31 clear while running does not disturb the current countdown. In repeat mode it is used at the next reload.
- R9: Zero written with bit 31 clear while running lets the current interval finish. The flag is set at terminal count and the channel then stops.
- R10: Address 0 reads back the last written bits 23:0, with bits 31:24 always zero. Address 1 reads the counter. Address 2 reads the flag in bit 0 and running in bit 1.
- R11: Writing zero to address 0 while idle leaves the channel idle with the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| repeat_mode | input | 1 | 1 = reload at terminal count, 0 = one-shot |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The assertions check the following on every cycle:
- the single-step countdown;
- the start from idle;
- the forced load and the forced stop;
- the one-shot stop;
- flag set at terminal count and its stickiness;
- the idle zero write;
- the zero upper read bits.

Some behaviour spans a whole interval, and only the bench's scenarios show it:
- the exact repeat period;
- a deferred retarget appearing only at the next reload;
- a deferred stop that still raises one last interrupt.

The random run compares every cycle against a bench model, including writes that land exactly on a terminal count.

// File: rtl/ivl_pkg.sv
package ivl_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_IVAL = 2'd0,
    REG_CNT  = 2'd1,
    REG_STAT = 2'd2
  } reg_sel_e;

  localparam int unsigned STAT_FLAG = 0;
  localparam int unsigned STAT_RUN  = 1;
endpackage

// File: rtl/ivl_core.sv
module ivl_core #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             repeat_mode,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_force,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             tc
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             upd_en;

  always_comb begin
    tc     = run_q && (cnt_q == '0);
    cnt_d  = cnt_q;
    run_d  = run_q;
    upd_en = ld_wr || run_q;
    if (ld_wr && !run_q) begin
      if (ld_val != '0) begin
        cnt_d = ld_val - ONE;
        run_d = 1'b1;
      end
    end else if (ld_wr && ld_force) begin
      if (ld_val == '0) begin
        cnt_d = '0;
        run_d = 1'b0;
      end else begin
        cnt_d = ld_val - ONE;
      end
    end else if (tc) begin
      if (repeat_mode && (reload_val != '0)) begin
        cnt_d = reload_val - ONE;
      end else begin
        run_d = 1'b0;
      end
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/ivl_regs.sv
module ivl_regs
  import ivl_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              tc,
  output logic              ld_wr,
  output logic [CNT_W-1:0]  ld_val,
  output logic              ld_force,
  output logic [CNT_W-1:0]  reload_val,
  output logic              flag
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;
  localparam int unsigned FORCE_BIT = DATA_W - 1;

  logic [CNT_W-1:0] ival_q, ival_d;
  logic             flag_q, flag_d;
  logic             flag_clr;

  always_comb begin
    ld_wr      = bus_wr && (bus_addr == REG_IVAL);
    ld_val     = bus_wdata[CNT_W-1:0];
    ld_force   = bus_wdata[FORCE_BIT];
    ival_d     = ld_wr ? ld_val : ival_q;
    reload_val = ival_d;
    flag_clr   = bus_wr && (bus_addr == REG_STAT) && bus_wdata[STAT_FLAG];
    flag_d     = tc ? 1'b1 : (flag_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
    end else if (ld_wr) begin
      ival_q <= ival_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (tc || flag_clr) begin
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_IVAL: bus_rdata = {{PAD_W{1'b0}}, ival_q};
      REG_CNT:  bus_rdata = {{PAD_W{1'b0}}, cnt};
      REG_STAT: begin
        bus_rdata[STAT_FLAG] = flag_q;
        bus_rdata[STAT_RUN]  = running;
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign flag = flag_q;
endmodule

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan
  import ivl_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              repeat_mode,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             ld_wr, ld_force, tc, running;
  logic [CNT_W-1:0] ld_val, reload_val, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ivl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cnt        (cnt),
    .running    (running),
    .tc         (tc),
    .ld_wr      (ld_wr),
    .ld_val     (ld_val),
    .ld_force   (ld_force),
    .reload_val (reload_val),
    .flag       (irq)
  );

  ivl_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .repeat_mode (repeat_mode),
    .ld_wr       (ld_wr),
    .ld_val      (ld_val),
    .ld_force    (ld_force),
    .reload_val  (reload_val),
    .cnt         (cnt),
    .running     (running),
    .tc          (tc)
  );
endmodule

// File: rtl/ivl_timer_chan_chk.sv
module ivl_timer_chan_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              repeat_mode,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              running
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             wr_ival, wr_clr, frc;
  logic [CNT_W-1:0] wv;

  assign wr_ival = bus_wr && (bus_addr == 2'd0);
  assign wr_clr  = bus_wr && (bus_addr == 2'd2) && bus_wdata[0];
  assign wv      = bus_wdata[CNT_W-1:0];
  assign frc     = bus_wdata[DATA_W-1];

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ival && !running && (wv != '0) |=> running && (cnt == $past(wv) - ONE));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running && (cnt != '0) && !wr_ival |=> cnt == $past(cnt) - ONE);

  assert_tc_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    running && (cnt == '0) |=> irq);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_clr |=> irq);

  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running && (cnt == '0) && !repeat_mode && !wr_ival |=> !running && (cnt == '0));

  assert_force_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_ival && frc && (wv != '0) |=> running && (cnt == $past(wv) - ONE));

  assert_force_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running && wr_ival && frc && (wv == '0) |=> !running && (cnt == '0));

  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !running && wr_ival && (wv == '0) |=> !running);
endmodule

bind ivl_timer_chan ivl_timer_chan_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .repeat_mode (repeat_mode),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .irq         (irq),
  .cnt         (cnt),
  .running     (running)
);

// File: tb/ivl_timer_chan_tb.sv
module ivl_timer_chan_tb;
  logic        clk;
  logic        rst_n;
  logic        repeat_mode;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk;
  int n_fail;

  logic [23:0] m_ival;
  logic [23:0] m_cnt;
  logic        m_run;
  logic        m_flag;

  ivl_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .repeat_mode(repeat_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {8'h00, m_ival};
      2'd1:    return {8'h00, m_cnt};
      2'd2:    return {30'd0, m_run, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_update(input logic w, input logic [1:0] a,
                              input logic [31:0] d, input logic rep);
    logic        tc;
    logic        wi;
    logic [23:0] v;
    logic [23:0] nival;
    tc    = m_run && (m_cnt == 24'd0);
    wi    = w && (a == 2'd0);
    v     = d[23:0];
    nival = wi ? v : m_ival;
    if (tc) m_flag = 1'b1;
    else if (w && a == 2'd2 && d[0]) m_flag = 1'b0;
    if (wi && !m_run) begin
      if (v != 24'd0) begin m_cnt = v - 24'd1; m_run = 1'b1; end
    end else if (wi && d[31]) begin
      if (v == 24'd0) begin m_cnt = 24'd0; m_run = 1'b0; end
      else m_cnt = v - 24'd1;
    end else if (tc) begin
      if (rep && nival != 24'd0) m_cnt = nival - 24'd1;
      else m_run = 1'b0;
    end else if (m_run) begin
      m_cnt = m_cnt - 24'd1;
    end
    m_ival = nival;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input string req);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_update(w, a, d, repeat_mode);
    @(negedge clk);
    chk({31'd0, irq}, {31'd0, m_flag}, req);
    chk(bus_rdata, exp_rd(a), req);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    m_ival = '0; m_cnt = '0; m_run = 1'b0; m_flag = 1'b0;
    rst_n = 1'b0; repeat_mode = 1'b0;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1");
    for (int a = 0; a < 3; a++) begin
      bus_addr = 2'(a); #1;
      chk(bus_rdata, 32'd0, "R1");
    end

    // R11 zero write while idle
    step(1'b1, 2'd0, 32'h8000_0000, "R11");
    step(1'b0, 2'd2, 32'd0, "R11");
    chk(bus_rdata, 32'd0, "R11");

    // R2 / R5 one-shot start with 5
    repeat_mode = 1'b0;
    step(1'b1, 2'd0, 32'd5, "R2");
    step(1'b0, 2'd1, 32'd0, "R2");
    chk(bus_rdata, 32'd3, "R2");
    step(1'b0, 2'd1, 32'd0, "R2");
    step(1'b0, 2'd1, 32'd0, "R2");
    step(1'b0, 2'd2, 32'd0, "R5");
    chk(bus_rdata, 32'd2, "R5");
    step(1'b0, 2'd2, 32'd0, "R5");
    chk(bus_rdata, 32'd1, "R5");
    step(1'b0, 2'd1, 32'd0, "R5");
    chk(bus_rdata, 32'd0, "R5");

    // R3 clear behaviour
    step(1'b1, 2'd2, 32'd0, "R3");
    chk({31'd0, irq}, 32'd1, "R3");
    step(1'b1, 2'd2, 32'd1, "R3");
    chk({31'd0, irq}, 32'd0, "R3");

    // R4 repeat period 3
    repeat_mode = 1'b1;
    step(1'b1, 2'd0, 32'd3, "R4");
    step(1'b0, 2'd2, 32'd0, "R4");
    step(1'b0, 2'd2, 32'd0, "R4");
    step(1'b0, 2'd2, 32'd0, "R4");
    chk(bus_rdata, 32'd3, "R4");
    step(1'b1, 2'd2, 32'd1, "R4");
    step(1'b0, 2'd2, 32'd0, "R4");
    step(1'b0, 2'd2, 32'd0, "R4");
    chk(bus_rdata, 32'd3, "R4");

    // R6 forced retarget
    step(1'b1, 2'd0, 32'h8000_0009, "R6");
    step(1'b0, 2'd1, 32'd0, "R6");
    chk(bus_rdata, 32'd7, "R6");

    // R10 read back without force bit
    step(1'b0, 2'd0, 32'd0, "R10");
    chk(bus_rdata, 32'd9, "R10");

    // R8 deferred retarget
    step(1'b1, 2'd0, 32'd4, "R8");
    chk(bus_rdata, 32'd4, "R10");
    step(1'b0, 2'd1, 32'd0, "R8");
    chk(bus_rdata, 32'd4, "R8");
    for (int i = 0; i < 6; i++) step(1'b0, 2'd1, 32'd0, "R8");
    chk(bus_rdata, 32'd2, "R8");

    // R9 deferred stop
    step(1'b1, 2'd2, 32'd1, "R9");
    step(1'b1, 2'd0, 32'd0, "R9");
    for (int i = 0; i < 4; i++) step(1'b0, 2'd2, 32'd0, "R9");
    chk(bus_rdata, 32'd1, "R9");

    // R7 forced stop
    step(1'b1, 2'd0, 32'd10, "R7");
    step(1'b0, 2'd2, 32'd0, "R7");
    step(1'b1, 2'd0, 32'h8000_0000, "R7");
    step(1'b0, 2'd2, 32'd0, "R7");
    chk(bus_rdata[1], 1'b0, "R7");
    step(1'b0, 2'd1, 32'd0, "R7");
    chk(bus_rdata, 32'd0, "R7");

    // randomized mix
    for (int i = 0; i < 4000; i++) begin
      logic        w;
      logic [1:0]  a;
      logic [31:0] d;
      if ($urandom_range(0, 49) == 0) repeat_mode = ~repeat_mode;
      w = ($urandom_range(0, 5) == 0);
      a = 2'($urandom_range(0, 3));
      d = {1'($urandom_range(0, 1)), 7'd0, 24'($urandom_range(0, 12))};
      step(w, a, d, "R10");
    end

    finish_run();
  end
endmodule